// File: doc/BRIEF.md
# Preemptible DMA Descriptor Loop Engine

This block is the control core of a multi-channel DMA controller. Every channel's transfer descriptor lives in a small register-based local store. Each descriptor holds a source and destination pointer, signed per-step offsets for both, a minor-loop byte count, a current and a starting iteration count, end-of-major pointer corrections and a few control bits. The store has one slot for each channel, plus a pool of spare slots that can be chained in when a major loop finishes. When a channel is chosen, its descriptor is copied into one of two working register sets. The engine then runs 32-bit read/write pairs on a simple single-cycle bus master port until the minor loop's byte count is used up.

The second working set lets a more urgent channel take over. If the running channel allows it, a higher-numbered channel with pending work may step in once the current read/write pair has finished. The interrupted channel keeps its advanced pointers and remaining byte count in its own set, and it continues after the newcomer's minor loop ends. At each minor-loop end the pointers and the iteration count go back to the store. At the end of a major loop the pointers get their final corrections and the iteration count is reloaded. If chaining is enabled, the pool descriptor replaces the channel's descriptor. A one-cycle completion pulse carries the channel number, and an optional sticky interrupt flag is set for that channel.

Top module: `dle_engine`

## Requirements
- R1: After reset no bus read or write is issued, `done` is low and every `irq` bit is 0.
- R2: Each transfer step reads one word from the working source pointer and writes it, unchanged, to the working destination pointer in the following cycle. Both pointers then advance by their own signed 16-bit offsets, sign-extended to 32 bits.
- R3: One activation performs nbytes/4 read/write pairs. At its end the source pointer, the destination pointer and the decremented iteration count are stored back, so the next activation continues from there.
- R4: When a minor loop ends with a current iteration count of 1 (or 0), the major loop is complete. The pointers receive the signed last-adjustment values, the current count is reloaded from the starting count, and `done` pulses for exactly one cycle with `done_ch` equal to the channel.
- R5: At major completion, `irq[ch]` is set only if the descriptor's interrupt-enable bit is 1. A bit of `irq` stays set until the same bit of `irq_clr` is pulsed.
- R6: Writing a descriptor to a channel slot with its start bit set requests one activation without any `hw_req`. The request is cleared when the channel is activated, so it runs only once.
- R7: Among pending requests, the highest channel index is served first.
- R8: A running channel whose preempt-enable bit is set hands over after a completed pair if a higher-index request is pending and the second working set is free. The newcomer runs its minor loop, and then the first channel resumes with the pointers and remaining count it had reached.
- R9: A running channel with preempt-enable clear completes its whole minor loop before any other channel is served.
- R10: At major completion with the chaining bit set, the channel's stored descriptor is replaced by the pool slot `NCH + link`, and the next activation uses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_req | input | NCH | One-cycle service request pulses, one per channel |
| cfg_we | input | 1 | Write a descriptor into the local store |
| cfg_idx | input | IDX_W | Store slot: channels 0..NCH-1, pool NCH..NCH+NPOOL-1 |
| cfg_tcd | input | TCD_W | Packed descriptor to write |
| rd_en | output | 1 | Bus read strobe |
| rd_addr | output | AW | Bus read address |
| rd_data | input | AW | Read data, valid in the same cycle as rd_en |
| wr_en | output | 1 | Bus write strobe |
| wr_addr | output | AW | Bus write address |
| wr_data | output | AW | Bus write data |
| irq | output | NCH | Sticky end-of-major interrupt flags |
| irq_clr | input | NCH | Clears the matching irq bits |
| done | output | 1 | One-cycle major-loop completion pulse |
| done_ch | output | IDX_W | Channel that completed, valid with done |

## Verification
The assertions check on every cycle the bus pair discipline: a read is always followed by a write, a write never appears without a read before it, and the two strobes are never active together. They also check that the completion pulse lasts a single cycle with an in-range channel, and that an interrupt bit rises only together with a completion. Preemption order, resumption from partially advanced pointers, write-back between activations, the final pointer corrections, chaining and the one-shot software start depend on descriptor contents and request timing. Only the directed scenarios can show these, by comparing the logged write addresses and data against values computed from the descriptors.

// File: rtl/dle_pkg.sv
package dle_pkg;
    parameter int AW    = 32;
    parameter int CW    = 16;
    parameter int IDX_W = 4;

    typedef struct packed {
        logic [AW-1:0]        saddr;
        logic [AW-1:0]        daddr;
        logic signed [CW-1:0] soff;
        logic signed [CW-1:0] doff;
        logic [CW-1:0]        nbytes;
        logic [CW-1:0]        citer;
        logic [CW-1:0]        biter;
        logic [AW-1:0]        slast;
        logic [AW-1:0]        dlast;
        logic                 start;
        logic                 int_maj;
        logic                 pre_en;
        logic                 sg_en;
        logic [IDX_W-1:0]     link;
    } tcd_t;

    typedef struct packed {
        tcd_t             t;
        logic [CW-1:0]    rem;
        logic [IDX_W-1:0] ch;
        logic             busy;
    } wset_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2,
        S_WB   = 2'd3
    } phase_e;

    localparam int TCD_W = $bits(tcd_t);
    localparam int BEAT  = AW / 8;
endpackage

// File: rtl/dle_arbiter.sv
module dle_arbiter
    import dle_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dle_step.sv
module dle_step
    import dle_pkg::*;
(
    input  wset_t         ws,
    output logic [AW-1:0] pair_saddr,
    output logic [AW-1:0] pair_daddr,
    output logic [CW-1:0] pair_rem,
    output logic          pair_last,
    output logic          major,
    output tcd_t          minor_t
);
    localparam int EXT = AW - CW;

    logic [AW-1:0] soff_x;
    logic [AW-1:0] doff_x;

    always_comb begin
        soff_x     = {{EXT{ws.t.soff[CW-1]}}, ws.t.soff};
        doff_x     = {{EXT{ws.t.doff[CW-1]}}, ws.t.doff};
        pair_saddr = ws.t.saddr + soff_x;
        pair_daddr = ws.t.daddr + doff_x;
        pair_last  = ws.rem <= CW'(BEAT);
        pair_rem   = pair_last ? '0 : ws.rem - CW'(BEAT);

        major         = ws.t.citer <= CW'(1);
        minor_t       = ws.t;
        minor_t.start = 1'b0;
        if (major) begin
            minor_t.saddr = ws.t.saddr + ws.t.slast;
            minor_t.daddr = ws.t.daddr + ws.t.dlast;
            minor_t.citer = ws.t.biter;
        end else begin
            minor_t.citer = ws.t.citer - CW'(1);
        end
    end
endmodule

// File: rtl/dle_engine.sv
module dle_engine
    import dle_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int NPOOL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   hw_req,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [TCD_W-1:0] cfg_tcd,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [AW-1:0]    rd_data,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [AW-1:0]    wr_data,
    output logic [NCH-1:0]   irq,
    input  logic [NCH-1:0]   irq_clr,
    output logic             done,
    output logic [IDX_W-1:0] done_ch
);
    localparam int NSLOT = NCH + NPOOL;

    typedef struct packed {
        phase_e           ph;
        wset_t [1:0]      ws;
        logic             act;
        logic [NCH-1:0]   pend;
        logic [NCH-1:0]   strt;
        logic [NCH-1:0]   irq;
        logic [AW-1:0]    dbuf;
        logic             done;
        logic [IDX_W-1:0] done_ch;
    } st_t;

    st_t  s_q, s_d;
    tcd_t mem_q [NSLOT];
    tcd_t mem_d [NSLOT];

    logic             arb_any;
    logic [IDX_W-1:0] arb_idx;
    wset_t            ws_act;
    logic [AW-1:0]    pair_saddr, pair_daddr;
    logic [CW-1:0]    pair_rem;
    logic             pair_last, major;
    tcd_t             minor_t;
    tcd_t             cfg_t;

    assign ws_act = s_q.ws[s_q.act];
    assign cfg_t  = tcd_t'(cfg_tcd);

    dle_arbiter #(.N(NCH)) u_arb (
        .req (s_q.pend | s_q.strt),
        .any (arb_any),
        .idx (arb_idx)
    );

    dle_step u_step (
        .ws         (ws_act),
        .pair_saddr (pair_saddr),
        .pair_daddr (pair_daddr),
        .pair_rem   (pair_rem),
        .pair_last  (pair_last),
        .major      (major),
        .minor_t    (minor_t)
    );

    always_comb begin
        s_d      = s_q;
        mem_d    = mem_q;
        s_d.done = 1'b0;
        s_d.pend = s_q.pend | hw_req;
        s_d.irq  = s_q.irq & ~irq_clr;

        unique case (s_q.ph)
            S_IDLE: begin
                if (arb_any) begin
                    s_d.ws[s_q.act].t    = mem_q[arb_idx];
                    s_d.ws[s_q.act].rem  = mem_q[arb_idx].nbytes;
                    s_d.ws[s_q.act].ch   = arb_idx;
                    s_d.ws[s_q.act].busy = 1'b1;
                    s_d.pend[arb_idx]    = 1'b0;
                    s_d.strt[arb_idx]    = 1'b0;
                    s_d.ph               = S_RD;
                end
            end
            S_RD: begin
                s_d.dbuf = rd_data;
                s_d.ph   = S_WR;
            end
            S_WR: begin
                s_d.ws[s_q.act].t.saddr = pair_saddr;
                s_d.ws[s_q.act].t.daddr = pair_daddr;
                s_d.ws[s_q.act].rem     = pair_rem;
                if (pair_last) begin
                    s_d.ph = S_WB;
                end else if (ws_act.t.pre_en && !s_q.ws[~s_q.act].busy &&
                             arb_any && (arb_idx > ws_act.ch)) begin
                    s_d.ws[~s_q.act].t    = mem_q[arb_idx];
                    s_d.ws[~s_q.act].rem  = mem_q[arb_idx].nbytes;
                    s_d.ws[~s_q.act].ch   = arb_idx;
                    s_d.ws[~s_q.act].busy = 1'b1;
                    s_d.pend[arb_idx]     = 1'b0;
                    s_d.strt[arb_idx]     = 1'b0;
                    s_d.act               = ~s_q.act;
                    s_d.ph                = S_RD;
                end else begin
                    s_d.ph = S_RD;
                end
            end
            S_WB: begin
                if (major) begin
                    s_d.done    = 1'b1;
                    s_d.done_ch = ws_act.ch;
                    if (ws_act.t.int_maj) s_d.irq[ws_act.ch] = 1'b1;
                end
                if (major && ws_act.t.sg_en) begin
                    mem_d[ws_act.ch]       = mem_q[NCH + int'(ws_act.t.link)];
                    mem_d[ws_act.ch].start = 1'b0;
                end else begin
                    mem_d[ws_act.ch].saddr = minor_t.saddr;
                    mem_d[ws_act.ch].daddr = minor_t.daddr;
                    mem_d[ws_act.ch].citer = minor_t.citer;
                    mem_d[ws_act.ch].start = 1'b0;
                end
                s_d.ws[s_q.act].busy = 1'b0;
                if (s_q.ws[~s_q.act].busy) begin
                    s_d.act = ~s_q.act;
                    s_d.ph  = S_RD;
                end else begin
                    s_d.ph = S_IDLE;
                end
            end
            default: s_d.ph = S_IDLE;
        endcase

        if (cfg_we) begin
            mem_d[cfg_idx] = cfg_t;
            if ((int'(cfg_idx) < NCH) && cfg_t.start) s_d.strt[cfg_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int i = 0; i < NSLOT; i++) mem_q[i] <= '0;
        end else begin
            s_q   <= s_d;
            mem_q <= mem_d;
        end
    end

    assign rd_en   = (s_q.ph == S_RD);
    assign rd_addr = ws_act.t.saddr;
    assign wr_en   = (s_q.ph == S_WR);
    assign wr_addr = ws_act.t.daddr;
    assign wr_data = s_q.dbuf;
    assign irq     = s_q.irq;
    assign done    = s_q.done;
    assign done_ch = s_q.done_ch;
endmodule

// File: rtl/dle_engine_chk.sv
module dle_engine_chk
    import dle_pkg::*;
#(
    parameter int NCH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic             done,
    input logic [IDX_W-1:0] done_ch,
    input logic [NCH-1:0]   irq
);
    // R2: a read is always answered by a write in the next cycle
    a_r2_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> wr_en);

    // R2: no write without the read of the same pair just before it
    a_r2_wr_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(rd_en));

    // R2: read and write strobes never overlap
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    // R4: completion is a single-cycle pulse
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: completion names an existing channel
    a_r4_done_ch_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(done_ch) < NCH));

    // R5: an interrupt flag rises only together with a completion
    a_r5_irq_rise_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> done);
endmodule

bind dle_engine dle_engine_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .done    (done),
    .done_ch (done_ch),
    .irq     (irq)
);

// File: tb/dle_engine_tb.sv
module dle_engine_tb;
    import dle_pkg::*;

    localparam int NCH   = 8;
    localparam int NPOOL = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   hw_req = '0;
    logic             cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [TCD_W-1:0] cfg_tcd = '0;
    logic             rd_en, wr_en, done;
    logic [AW-1:0]    rd_addr, rd_data, wr_addr, wr_data;
    logic [NCH-1:0]   irq;
    logic [NCH-1:0]   irq_clr = '0;
    logic [IDX_W-1:0] done_ch;

    int vectors = 0;
    int miss    = 0;
    bit finished = 0;

    logic [31:0] wa [256];
    logic [31:0] wd [256];
    int          wn = 0;
    int          dch [64];
    int          dn = 0;

    always #2 clk = ~clk;

    assign rd_data = ~rd_addr;

    dle_engine #(.NCH(NCH), .NPOOL(NPOOL)) u_dut (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tcd(cfg_tcd),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .irq(irq), .irq_clr(irq_clr), .done(done), .done_ch(done_ch)
    );

    always @(negedge clk) begin
        if (rst_n && wr_en && wn < 256) begin
            wa[wn] = wr_addr;
            wd[wn] = wr_data;
            wn++;
        end
        if (rst_n && done && dn < 64) begin
            dch[dn] = int'(done_ch);
            dn++;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put_tcd(int idx, logic [31:0] sa, logic [31:0] da,
                           logic [15:0] so, logic [15:0] dof, logic [15:0] nb,
                           logic [15:0] ci, logic [31:0] sl, logic [31:0] dl,
                           bit st, bit im, bit pe, bit sg, int lk);
        tcd_t t;
        t = '0;
        t.saddr = sa;  t.daddr = da;
        t.soff = so;   t.doff = dof;
        t.nbytes = nb; t.citer = ci; t.biter = ci;
        t.slast = sl;  t.dlast = dl;
        t.start = st;  t.int_maj = im; t.pre_en = pe; t.sg_en = sg;
        t.link = IDX_W'(lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_tcd = t;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(logic [NCH-1:0] m);
        @(negedge clk);
        hw_req = m;
        @(negedge clk);
        hw_req = '0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 rd_en after reset", 32'(rd_en), 32'd0);
        check("R1 wr_en after reset", 32'(wr_en), 32'd0);
        check("R1 done after reset", 32'(done), 32'd0);
        check("R1 irq after reset", 32'(irq), 32'd0);
    endtask

    task automatic t_basic();
        int w0, d0;
        put_tcd(2, 32'h1000, 32'h2000, 16'd4, 16'd4, 16'd12, 16'd2,
                -32'sd24, -32'sd24, 0, 1, 0, 0, 0);
        w0 = wn; d0 = dn;
        pulse(8'h04); settle();
        check("R3 pairs per minor loop", 32'(wn - w0), 32'd3);
        for (int k = 0; k < 3; k++) begin
            check("R2 write address", wa[w0+k], 32'h2000 + 32'(4*k));
            check("R2 write data", wd[w0+k], ~(32'h1000 + 32'(4*k)));
        end
        check("R4 no done mid major", 32'(dn - d0), 32'd0);
        w0 = wn;
        pulse(8'h04); settle();
        check("R3 resumed dest", wa[w0], 32'h200C);
        check("R3 resumed data", wd[w0+2], ~32'h1014);
        check("R4 done count", 32'(dn - d0), 32'd1);
        check("R4 done channel", 32'(dch[d0]), 32'd2);
        check("R5 irq set", 32'(irq), 32'h04);
        w0 = wn; d0 = dn;
        pulse(8'h04); settle();
        check("R4 last adjust dest", wa[w0], 32'h2000);
        check("R4 last adjust src", wd[w0], ~32'h1000);
        check("R4 citer reloaded", 32'(dn - d0), 32'd0);
    endtask

    task automatic t_negoff();
        int w0, d0;
        put_tcd(1, 32'h1100, 32'h3000, 16'hFFFC, 16'd8, 16'd8, 16'd1,
                0, 0, 0, 0, 0, 0, 0);
        w0 = wn; d0 = dn;
        pulse(8'h02); settle();
        check("R2 dest step", wa[w0+1], 32'h3008);
        check("R2 negative src step", wd[w0+1], ~32'h10FC);
        check("R4 done ch1", 32'(dch[d0]), 32'd1);
        check("R5 no irq when disabled", 32'(irq), 32'h04);
        @(negedge clk); irq_clr = 8'h04;
        @(negedge clk); irq_clr = '0;
        @(negedge clk);
        check("R5 irq cleared", 32'(irq), 32'h00);
    endtask

    task automatic t_start();
        int w0;
        w0 = wn;
        put_tcd(3, 32'h1200, 32'h4000, 16'd4, 16'd4, 16'd4, 16'd5,
                0, 0, 1, 0, 0, 0, 0);
        settle(); settle();
        check("R6 one software run", 32'(wn - w0), 32'd1);
        check("R6 start dest", wa[w0], 32'h4000);
    endtask

    task automatic t_prio();
        int w0;
        put_tcd(1, 32'h1500, 32'h5100, 16'd4, 16'd4, 16'd8, 16'd3, 0, 0, 0, 0, 0, 0, 0);
        put_tcd(4, 32'h1600, 32'h5400, 16'd4, 16'd4, 16'd8, 16'd3, 0, 0, 0, 0, 0, 0, 0);
        w0 = wn;
        pulse(8'h12); settle();
        check("R7 high first", wa[w0], 32'h5400);
        check("R7 high second", wa[w0+1], 32'h5404);
        check("R7 low after", wa[w0+2], 32'h5100);
        check("R7 low last", wa[w0+3], 32'h5104);
    endtask

    task automatic t_preempt(bit pe, logic [31:0] base);
        int w0;
        logic [31:0] exp [6];
        put_tcd(0, 32'h1300, base, 16'd4, 16'd4, 16'd16, 16'd3, 0, 0, 0, 0, pe, 0, 0);
        put_tcd(5, 32'h1700, 32'h8600, 16'd4, 16'd4, 16'd8, 16'd3, 0, 0, 0, 0, 0, 0, 0);
        w0 = wn;
        pulse(8'h01);
        while (!wr_en) @(negedge clk);
        hw_req = 8'h20;
        @(negedge clk);
        hw_req = '0;
        settle();
        if (pe) begin
            exp = '{base, base + 4, 32'h8600, 32'h8604, base + 8, base + 12};
        end else begin
            exp = '{base, base + 4, base + 8, base + 12, 32'h8600, 32'h8604};
        end
        for (int k = 0; k < 6; k++) begin
            if (pe) check("R8 preempt order", wa[w0+k], exp[k]);
            else    check("R9 no preempt order", wa[w0+k], exp[k]);
        end
        if (pe) check("R8 resumed src", wd[w0+4], ~32'h1308);
    endtask

    task automatic t_sg();
        int w0, d0;
        put_tcd(NCH + 1, 32'h1400, 32'h7000, 16'd4, 16'd4, 16'd4, 16'd2, 0, 0, 0, 0, 0, 0, 0);
        put_tcd(6, 32'h1800, 32'h6000, 16'd4, 16'd4, 16'd4, 16'd1, 0, 0, 0, 0, 0, 1, 1);
        w0 = wn; d0 = dn;
        pulse(8'h40); settle();
        check("R10 first dest", wa[w0], 32'h6000);
        check("R10 done ch6", 32'(dch[d0]), 32'd6);
        w0 = wn; d0 = dn;
        pulse(8'h40); settle();
        check("R10 chained dest", wa[w0], 32'h7000);
        check("R10 chained src", wd[w0], ~32'h1400);
        check("R10 chained citer", 32'(dn - d0), 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_negoff();
        t_start();
        t_prio();
        t_preempt(1'b1, 32'h8000);
        t_preempt(1'b0, 32'h8100);
        t_sg();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miss++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end
endmodule